// File: doc/BRIEF.md
# Double-Banked Bulk-Out Receive Buffer

This block buffers the payload of one USB bulk-out endpoint between a serial interface engine and a processor. It holds two banks of equal size. At any time one bank is filled by the engine and the other is drained by the processor, and the two trade places on their own whenever the engine side holds a complete good packet and the processor side has nothing left to read.

The engine side writes bytes with a strobe and closes each packet with a good-end or bad-end pulse. The processor side reads bytes through an 8-bit port that only supports reads. It sees the remaining byte count and a data-ready flag. Each swap produces a one-cycle request pulse, sent either as an interrupt or as a DMA request depending on a mode input. If a packet arrives while both banks are busy, the endpoint stalls and the processor bank is discarded. A not-acknowledge enable flag, which the processor sets, is cleared by every swap.

Top module: `bulk_out_pingpong`

## Requirements
- R1: After reset, rx_len is 0, data_ready is 0, stall is 0, irq_req and dma_req are 0, and nak_en is 0. Bank 0 faces the engine.
- R2: A swap happens only when the engine bank holds a committed packet and rx_len is 0. It takes effect on the clock edge after the cycle in which both conditions are true. A committed packet waits while rx_len is nonzero.
- R3: On a swap, rx_len loads the packet byte count, data_ready goes to 1, and cpu_rd_data shows byte 0 of the new packet.
- R4: A swap raises a one-cycle pulse on irq_req when dma_mode is 0, or on dma_req when dma_mode is 1. The pulse appears in the same cycle that data_ready rises, and the two requests never assert together.
- R5: Each cpu_rd_en while rx_len > 0 moves to the next byte and decrements rx_len. data_ready clears when rx_len reaches 0.
- R6: If a packet is waiting when rx_len reaches 0, the swap follows, and further reads return the waiting packet starting at its byte 0.
- R7: If no packet is waiting, reads past the count return byte 0 of the drained bank again, and rx_len stays 0.
- R8: A good end while the engine bank is full and rx_len is nonzero sets stall, which stays high until reset. It also forces rx_len and data_ready to 0 on that edge, and the overrunning packet's data is dropped.
- R9: A bad end discards the bytes written since the last end pulse. It causes no swap and no request, and the next packet starts at byte 0.
- R10: A nak_set pulse sets nak_en to 1, and every swap clears it.
- R11: A packet longer than BANK_BYTES keeps its first BANK_BYTES bytes, and its length is capped at BANK_BYTES. Writes made while the engine bank is full, or in the same cycle as an end pulse, are dropped.
- R12: A good end with no bytes written is discarded, with no swap and no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sie_wr_en | input | 1 | Engine byte write strobe |
| sie_wr_data | input | DATA_W | Engine byte |
| sie_pkt_good | input | 1 | Packet ended without error |
| sie_pkt_bad | input | 1 | Packet ended with error |
| cpu_rd_en | input | 1 | Processor consumes the byte on cpu_rd_data |
| cpu_rd_data | output | DATA_W | Current byte of processor bank |
| rx_len | output | $clog2(BANK_BYTES+1) | Bytes left to read |
| data_ready | output | 1 | Processor bank holds unread data |
| dma_mode | input | 1 | 0: interrupt request, 1: DMA request |
| irq_req | output | 1 | Swap notification as interrupt |
| dma_req | output | 1 | Swap notification as DMA request |
| nak_set | input | 1 | Set the not-acknowledge enable flag |
| nak_en | output | 1 | Not-acknowledge enable flag |
| stall | output | 1 | Endpoint stalled after overrun |

## Verification
Packets of several lengths are sent: 1 to 5 bytes, a full bank, and longer than a bank. These show whether the count is loaded and capped correctly and whether bytes come back in order. Three read patterns follow a packet: reading exactly the count, over-reading with nothing queued, and over-reading with a queued packet. They separate the stale-byte repeat from the hand-over to the next packet. Bad-ended, empty and overrunning packets confirm that a discard leaves no swap or request behind. The overrun case also checks that the queued packet survives while the processor bank is flushed.

// File: rtl/bo_pp_pkg.sv
package bo_pp_pkg;
  typedef enum logic {NOTIFY_IRQ = 1'b0, NOTIFY_DMA = 1'b1} notify_e;

  // banks trade places when a good packet waits and the reader is empty
  function automatic logic swap_ready(logic sie_full, logic cpu_empty);
    return sie_full & cpu_empty;
  endfunction

  // a new good packet with nowhere to go
  function automatic logic is_overrun(logic good_end, logic sie_full, logic cpu_empty);
    return good_end & sie_full & ~cpu_empty;
  endfunction
endpackage

// File: rtl/bo_pp_bank.sv
module bo_pp_bank #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/bo_pp_sie_side.sv
module bo_pp_sie_side #(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             pkt_good,
  input  logic             pkt_bad,
  input  logic             cpu_empty,
  input  logic             swap,
  output logic             we,
  output logic [PTR_W-1:0] waddr,
  output logic             full,
  output logic [CNT_W-1:0] pkt_len,
  output logic             overrun
);
  import bo_pp_pkg::*;

  logic [CNT_W-1:0] wr_cnt;
  logic             room;
  logic             commit;

  assign room    = wr_cnt < CNT_W'(DEPTH);
  assign we      = wr_en & ~full & room & ~pkt_good & ~pkt_bad;
  assign waddr   = wr_cnt[PTR_W-1:0];
  assign overrun = is_overrun(pkt_good, full, cpu_empty);
  assign commit  = pkt_good & ~full & (wr_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_cnt  <= '0;
      full    <= 1'b0;
      pkt_len <= '0;
    end else begin
      if (swap) begin
        full   <= 1'b0;
        wr_cnt <= '0;
      end else if (pkt_good || pkt_bad) begin
        wr_cnt <= '0;
        if (commit) begin
          full    <= 1'b1;
          pkt_len <= wr_cnt;
        end
      end else if (we) begin
        wr_cnt <= wr_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bo_pp_cpu_side.sv
module bo_pp_cpu_side #(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             swap,
  input  logic [CNT_W-1:0] new_len,
  input  logic             flush,
  output logic [CNT_W-1:0] cnt,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             ready
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      rd_ptr <= '0;
      ready  <= 1'b0;
    end else if (swap) begin
      cnt    <= new_len;
      rd_ptr <= '0;
      ready  <= new_len != '0;
    end else if (flush) begin
      cnt    <= '0;
      rd_ptr <= '0;
      ready  <= 1'b0;
    end else if (rd_en) begin
      if (cnt > CNT_W'(1)) begin
        cnt    <= cnt - 1'b1;
        rd_ptr <= rd_ptr + 1'b1;
      end else begin
        cnt    <= '0;
        rd_ptr <= '0;
        ready  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bulk_out_pingpong.sv
module bulk_out_pingpong #(
  parameter int BANK_BYTES = 64,
  parameter int DATA_W     = 8,
  localparam int PTR_W     = $clog2(BANK_BYTES),
  localparam int CNT_W     = $clog2(BANK_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sie_wr_en,
  input  logic [DATA_W-1:0] sie_wr_data,
  input  logic              sie_pkt_good,
  input  logic              sie_pkt_bad,
  input  logic              cpu_rd_en,
  output logic [DATA_W-1:0] cpu_rd_data,
  output logic [CNT_W-1:0]  rx_len,
  output logic              data_ready,
  input  logic              dma_mode,
  output logic              irq_req,
  output logic              dma_req,
  input  logic              nak_set,
  output logic              nak_en,
  output logic              stall
);
  import bo_pp_pkg::*;

  logic             sel;        // bank index facing the engine
  logic             sie_we;
  logic [PTR_W-1:0] sie_waddr;
  logic             sie_full;
  logic [CNT_W-1:0] sie_len;
  logic             overrun_evt;
  logic             swap_evt;
  logic             cpu_empty;
  logic [PTR_W-1:0] rd_ptr;
  logic [DATA_W-1:0] bank_rd [2];
  notify_e          mode;

  assign cpu_empty = rx_len == '0;
  assign swap_evt  = swap_ready(sie_full, cpu_empty);
  assign mode      = notify_e'(dma_mode);

  bo_pp_sie_side #(.DEPTH(BANK_BYTES)) u_sie (
    .clk(clk), .rst_n(rst_n), .wr_en(sie_wr_en), .pkt_good(sie_pkt_good),
    .pkt_bad(sie_pkt_bad), .cpu_empty(cpu_empty), .swap(swap_evt),
    .we(sie_we), .waddr(sie_waddr), .full(sie_full), .pkt_len(sie_len),
    .overrun(overrun_evt)
  );

  bo_pp_cpu_side #(.DEPTH(BANK_BYTES)) u_cpu (
    .clk(clk), .rst_n(rst_n), .rd_en(cpu_rd_en), .swap(swap_evt),
    .new_len(sie_len), .flush(overrun_evt), .cnt(rx_len), .rd_ptr(rd_ptr),
    .ready(data_ready)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic bank_we;
    assign bank_we = sie_we & (sel == b[0]);
    bo_pp_bank #(.DEPTH(BANK_BYTES), .DATA_W(DATA_W)) u_bank (
      .clk(clk), .we(bank_we), .waddr(sie_waddr), .wdata(sie_wr_data),
      .raddr(rd_ptr), .rdata(bank_rd[b])
    );
  end

  assign cpu_rd_data = sel ? bank_rd[0] : bank_rd[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel     <= 1'b0;
      irq_req <= 1'b0;
      dma_req <= 1'b0;
      stall   <= 1'b0;
      nak_en  <= 1'b0;
    end else begin
      irq_req <= swap_evt & (mode == NOTIFY_IRQ);
      dma_req <= swap_evt & (mode == NOTIFY_DMA);
      if (swap_evt) sel <= ~sel;
      if (overrun_evt) stall <= 1'b1;
      if (swap_evt) nak_en <= 1'b0;
      else if (nak_set) nak_en <= 1'b1;
    end
  end
endmodule

// File: rtl/bo_pp_chk.sv
module bo_pp_chk #(
  parameter int BANK_BYTES = 64,
  localparam int CNT_W = $clog2(BANK_BYTES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             swap_evt,
  input logic             overrun_evt,
  input logic             sel,
  input logic             irq_req,
  input logic             dma_req,
  input logic             data_ready,
  input logic [CNT_W-1:0] rx_len,
  input logic             stall,
  input logic             nak_en
);
  p_len_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_len <= CNT_W'(BANK_BYTES));

  p_sel_flips_r2: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |=> sel != $past(sel));

  p_swap_on_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != $past(sel)) |-> ($past(rx_len) == '0));

  p_req_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_req, dma_req}));

  p_req_with_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req || dma_req) |-> data_ready);

  p_ready_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_len == '0) |-> !data_ready);

  p_stall_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> stall);

  p_overrun_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> (stall && rx_len == '0));

  p_nak_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |=> !nak_en);
endmodule

bind bulk_out_pingpong bo_pp_chk #(.BANK_BYTES(BANK_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .swap_evt(swap_evt), .overrun_evt(overrun_evt),
  .sel(sel), .irq_req(irq_req), .dma_req(dma_req), .data_ready(data_ready),
  .rx_len(rx_len), .stall(stall), .nak_en(nak_en)
);

// File: tb/tb_bulk_out_pingpong.sv
module tb_bulk_out_pingpong;
  localparam int CLK_PERIOD = 10;
  localparam int BANK = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sie_wr_en = 0, sie_pkt_good = 0, sie_pkt_bad = 0;
  logic [7:0] sie_wr_data = '0;
  logic       cpu_rd_en = 0, dma_mode = 0, nak_set = 0;
  logic [7:0] cpu_rd_data;
  logic [6:0] rx_len;
  logic       data_ready, irq_req, dma_req, nak_en, stall;

  int n_chk = 0;
  int n_bad = 0;

  bulk_out_pingpong #(.BANK_BYTES(BANK), .DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .sie_wr_en(sie_wr_en), .sie_wr_data(sie_wr_data),
    .sie_pkt_good(sie_pkt_good), .sie_pkt_bad(sie_pkt_bad), .cpu_rd_en(cpu_rd_en),
    .cpu_rd_data(cpu_rd_data), .rx_len(rx_len), .data_ready(data_ready),
    .dma_mode(dma_mode), .irq_req(irq_req), .dma_req(dma_req), .nak_set(nak_set),
    .nak_en(nak_en), .stall(stall)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    cyc(3);
    rst_n = 1;
    cyc(1);
  endtask

  // writes n bytes base+i, then ends; returns at the negedge after the end edge
  task automatic send(int n, int base, bit good);
    for (int i = 0; i < n; i++) begin
      sie_wr_en = 1; sie_wr_data = 8'(base + i);
      cyc(1);
    end
    sie_wr_en = 0;
    sie_pkt_good = good; sie_pkt_bad = !good;
    cyc(1);
    sie_pkt_good = 0; sie_pkt_bad = 0;
  endtask

  task automatic rd(output int val);
    val = cpu_rd_data;
    cpu_rd_en = 1;
    cyc(1);
    cpu_rd_en = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 rx_len", rx_len, 0);
    chk("R1 ready", data_ready, 0);
    chk("R1 stall", stall, 0);
    chk("R1 req", irq_req | dma_req, 0);
    chk("R1 nak", nak_en, 0);
  endtask

  task automatic t_basic();
    int v;
    do_reset();
    dma_mode = 0;
    send(5, 8'h10, 1);
    chk("R2 not yet swapped", rx_len, 0);
    cyc(1);
    chk("R3 len", rx_len, 5);
    chk("R3 ready", data_ready, 1);
    chk("R4 irq pulse", irq_req, 1);
    chk("R4 no dma", dma_req, 0);
    for (int i = 0; i < 5; i++) begin
      rd(v);
      chk("R5 data", v, 8'h10 + i);
      chk("R5 len", rx_len, 4 - i);
      if (i == 0) chk("R4 pulse one cycle", irq_req, 0);
    end
    chk("R5 ready cleared", data_ready, 0);
  endtask

  task automatic t_dma();
    do_reset();
    dma_mode = 1;
    send(3, 8'h33, 1);
    cyc(1);
    chk("R4 dma pulse", dma_req, 1);
    chk("R4 irq quiet", irq_req, 0);
    cyc(1);
    chk("R4 dma one cycle", dma_req, 0);
    dma_mode = 0;
  endtask

  task automatic t_wrap();
    int v;
    do_reset();
    send(2, 8'h40, 1);
    cyc(1);
    rd(v); rd(v);
    chk("R7 len zero", rx_len, 0);
    rd(v);
    chk("R7 repeat byte0", v, 8'h40);
    rd(v);
    chk("R7 repeat again", v, 8'h40);
    chk("R7 len stays", rx_len, 0);
  endtask

  task automatic t_chain();
    int v;
    do_reset();
    send(3, 8'h20, 1);
    cyc(1);
    nak_set = 1; cyc(1); nak_set = 0;
    chk("R10 nak set", nak_en, 1);
    send(4, 8'h60, 1);
    cyc(3);
    chk("R2 waits while busy", rx_len, 3);
    chk("R2 old data kept", cpu_rd_data, 8'h20);
    for (int i = 0; i < 3; i++) rd(v);
    cyc(1);
    chk("R6 next len", rx_len, 4);
    chk("R10 nak cleared", nak_en, 0);
    rd(v);
    chk("R6 next byte0", v, 8'h60);
    rd(v);
    chk("R6 next byte1", v, 8'h61);
  endtask

  task automatic t_overrun();
    do_reset();
    send(3, 8'h01, 1);
    cyc(1);
    send(2, 8'h50, 1);
    cyc(2);
    chk("R8 held", rx_len, 3);
    send(2, 8'h90, 1);
    chk("R8 stall", stall, 1);
    chk("R8 flushed", rx_len, 0);
    chk("R8 ready low", data_ready, 0);
    cyc(1);
    chk("R8 queued pkt len", rx_len, 2);
    chk("R8 queued pkt data", cpu_rd_data, 8'h50);
    cyc(3);
    chk("R8 stall sticky", stall, 1);
  endtask

  task automatic t_bad();
    int seen;
    do_reset();
    send(4, 8'hA0, 0);
    seen = 0;
    for (int i = 0; i < 4; i++) begin
      seen |= irq_req | dma_req;
      cyc(1);
    end
    chk("R9 no request", seen, 0);
    chk("R9 no swap", rx_len, 0);
    send(2, 8'h70, 1);
    cyc(1);
    chk("R9 next len", rx_len, 2);
    chk("R9 next byte0", cpu_rd_data, 8'h70);
  endtask

  task automatic t_zero();
    int seen;
    do_reset();
    send(0, 0, 1);
    seen = 0;
    for (int i = 0; i < 4; i++) begin
      seen |= irq_req | dma_req;
      cyc(1);
    end
    chk("R12 no request", seen, 0);
    chk("R12 len", rx_len, 0);
  endtask

  task automatic t_long();
    int v, errs;
    do_reset();
    send(BANK + 2, 0, 1);
    cyc(1);
    chk("R11 len capped", rx_len, BANK);
    errs = 0;
    for (int i = 0; i < BANK; i++) begin
      rd(v);
      if (v != i) errs++;
    end
    chk("R11 bytes kept", errs, 0);
    chk("R11 drained", rx_len, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_dma();
    t_wrap();
    t_chain();
    t_overrun();
    t_bad();
    t_zero();
    t_long();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule